// File: doc/BRIEF.md
# Retired-Instruction Flow Checker

This block watches the instruction trace of a small processor without touching it. On every trace beat the processor reports the address of an instruction it has just retired, the 18-bit instruction word and a flag saying that the instruction was interrupted. The checker decodes the instruction class. It works out which addresses may legally retire next. When the next beat arrives, it compares that beat's address with the allowed set. Any disagreement sets a sticky error output that stays high until reset.

Calls and interrupts leave their return address in a shallow shadow stack. Returns are checked against the newest entry. Conditional forms are accepted whether the branch was taken or not, because the trace does not carry the condition outcome. The stack update of a conditional form waits until the next beat shows which way it went. The checker needs no stored signatures and no changes to the program being checked.

Top module: `cfc_monitor`

## Requirements
- R1: While reset is held and after it is released, `cf_error` is low. The first valid beat after reset is never compared, because no prediction exists yet.
- R2: An instruction whose opcode field `tr_insn[17:13]` is none of the six control codes allows only `pc+1` next. Addresses wrap modulo 1024, so 1023 is followed by 0.
- R3: Opcode 5'h1A is an unconditional jump. The next beat must carry `pc + tr_insn[9:0]` modulo 1024. The sequential address is an error unless it equals that target.
- R4: Opcode 5'h1B is a conditional jump. Both `pc+1` and the target `pc + tr_insn[9:0]` are accepted, and any other address is an error.
- R5: Opcode 5'h18 is a call. The next address must be its target, and `pc+1` is pushed onto the shadow stack. Opcode 5'h15 is a return. When the stack is non-empty, the next address must equal the newest entry, which is then popped.
- R6: Opcode 5'h19 is a conditional call. It pushes `pc+1` only when the next address equals its target. Opcode 5'h14 is a conditional return. It accepts the newest stack entry or `pc+1`, and it pops only when the next address equals the newest entry.
- R7: The stack holds `RAS_DEPTH` entries (3 by default). A push when the stack is full discards the oldest entry. A return or conditional return with an empty stack accepts any next address and raises no error.
- R8: A beat with `tr_trap` high overrides its instruction class. The next address must be `VEC_ADDR` (default 10'h010), and `pc+1` is pushed as a return address.
- R9: `cf_error` rises on the clock edge that samples the first offending beat. It then stays high until reset.
- R10: Cycles with `tr_valid` low are ignored, whatever the other trace inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tr_valid | input | 1 | Trace beat present this cycle |
| tr_pc | input | 10 | Address of the retired instruction |
| tr_insn | input | 18 | Retired instruction word |
| tr_trap | input | 1 | Instruction was interrupted and the processor vectors to the handler |
| cf_error | output | 1 | Sticky control-flow error |

## Verification
A wrong internal state shows up at `cf_error` at the latest on the edge that samples the beat after the faulty prediction. The only exceptions are stack entries, which are consulted one return later. The stack contents are therefore exposed through the ports by running call and return sequences. These include overflow, an empty stack, and conditional forms that must not push or pop; afterwards a later return proves which entry sits on top. Jump targets are swept over many offsets with wraparound, and the sequential rule is swept over the whole 1024-word space.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OPC_JMP   = 5'h1A;
  localparam logic [OPC_W-1:0] OPC_JCC   = 5'h1B;
  localparam logic [OPC_W-1:0] OPC_CALL  = 5'h18;
  localparam logic [OPC_W-1:0] OPC_CALLC = 5'h19;
  localparam logic [OPC_W-1:0] OPC_RET   = 5'h15;
  localparam logic [OPC_W-1:0] OPC_RETC  = 5'h14;

  typedef enum logic [2:0] {
    CL_SEQ, CL_JMP, CL_JCC, CL_CALL, CL_CALLC, CL_RET, CL_RETC
  } insn_class_e;
endpackage

// File: rtl/cfc_decode.sv
module cfc_decode
  import cfc_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int INSN_W = 18
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [INSN_W-1:0] insn_i,
  output insn_class_e       cls_o,
  output logic [PC_W-1:0]   seq_o,
  output logic [PC_W-1:0]   tgt_o
);
  logic [OPC_W-1:0] opc;
  logic [PC_W-1:0]  offs;

  assign opc  = insn_i[INSN_W-1 -: OPC_W];
  assign offs = insn_i[PC_W-1:0];
  assign seq_o = pc_i + PC_W'(1);
  assign tgt_o = pc_i + offs;

  always_comb begin
    case (opc)
      OPC_JMP:   cls_o = CL_JMP;
      OPC_JCC:   cls_o = CL_JCC;
      OPC_CALL:  cls_o = CL_CALL;
      OPC_CALLC: cls_o = CL_CALLC;
      OPC_RET:   cls_o = CL_RET;
      OPC_RETC:  cls_o = CL_RETC;
      default:   cls_o = CL_SEQ;
    endcase
  end
endmodule

// File: rtl/cfc_ras.sv
module cfc_ras #(
  parameter int DEPTH = 3,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [W-1:0]     ent_q   [DEPTH];
  logic [W-1:0]     ent_nxt [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] from_up, from_dn;
    if (i == 0) begin : g_head
      assign from_up = din_i;
    end else begin : g_body
      assign from_up = ent_q[i-1];
    end
    if (i == DEPTH - 1) begin : g_tail
      assign from_dn = '0;
    end else begin : g_mid
      assign from_dn = ent_q[i+1];
    end
    always_comb begin
      if (push_i)     ent_nxt[i] = from_up;
      else if (pop_i) ent_nxt[i] = from_dn;
      else            ent_nxt[i] = ent_q[i];
    end
  end

  always_comb begin
    cnt_nxt = cnt_q;
    if (push_i && cnt_q != CNT_MAX)    cnt_nxt = cnt_q + CNT_W'(1);
    else if (pop_i && cnt_q != '0)     cnt_nxt = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= ent_nxt[k];
    end
  end

  assign top_o   = ent_q[0];
  assign empty_o = (cnt_q == '0);

  // R7
  ras_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  // R5
  ras_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> (!empty_o && top_o == $past(din_i)));
  // R7
  ras_emptypop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o) |=> empty_o);
  // R6
  ras_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));
endmodule

// File: rtl/cfc_monitor.sv
module cfc_monitor
  import cfc_pkg::*;
#(
  parameter int              PC_W      = 10,
  parameter int              INSN_W    = 18,
  parameter int              RAS_DEPTH = 3,
  parameter logic [PC_W-1:0] VEC_ADDR  = 10'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tr_valid,
  input  logic [PC_W-1:0]   tr_pc,
  input  logic [INSN_W-1:0] tr_insn,
  input  logic              tr_trap,
  output logic              cf_error
);
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  insn_class_e     cur_cls;
  logic [PC_W-1:0] cur_seq, cur_tgt;

  cfc_decode #(.PC_W(PC_W), .INSN_W(INSN_W)) u_dec (
    .pc_i(tr_pc), .insn_i(tr_insn),
    .cls_o(cur_cls), .seq_o(cur_seq), .tgt_o(cur_tgt)
  );

  logic            prv_vld, prv_trap;
  insn_class_e     prv_cls;
  logic [PC_W-1:0] prv_seq, prv_tgt;

  logic            ras_push, ras_pop, ras_empty;
  logic [PC_W-1:0] ras_top;

  cfc_ras #(.DEPTH(RAS_DEPTH), .W(PC_W)) u_ras (
    .clk(clk), .rst_n(rst_sync_n),
    .push_i(ras_push), .pop_i(ras_pop), .din_i(prv_seq),
    .top_o(ras_top), .empty_o(ras_empty)
  );

  logic chk, ok, push_c, pop_c, hit_seq, hit_tgt, hit_top;
  logic err_q, err_nxt;

  assign chk     = tr_valid && prv_vld;
  assign hit_seq = (tr_pc == prv_seq);
  assign hit_tgt = (tr_pc == prv_tgt);
  assign hit_top = !ras_empty && (tr_pc == ras_top);

  always_comb begin
    ok = 1'b1; push_c = 1'b0; pop_c = 1'b0;
    if (prv_trap) begin
      ok = (tr_pc == VEC_ADDR); push_c = 1'b1;
    end else begin
      case (prv_cls)
        CL_JMP:   ok = hit_tgt;
        CL_JCC:   ok = hit_tgt || hit_seq;
        CL_CALL:  begin ok = hit_tgt; push_c = 1'b1; end
        CL_CALLC: begin ok = hit_tgt || hit_seq; push_c = hit_tgt; end
        CL_RET:   begin ok = ras_empty || hit_top; pop_c = !ras_empty; end
        CL_RETC:  begin ok = ras_empty || hit_top || hit_seq; pop_c = hit_top; end
        default:  ok = hit_seq;
      endcase
    end
  end

  assign ras_push = chk && push_c;
  assign ras_pop  = chk && pop_c;
  assign err_nxt  = err_q || (chk && !ok);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prv_vld <= 1'b0; prv_trap <= 1'b0; prv_cls <= CL_SEQ;
      prv_seq <= '0;   prv_tgt  <= '0;
    end else if (tr_valid) begin
      prv_vld <= 1'b1; prv_trap <= tr_trap; prv_cls <= cur_cls;
      prv_seq <= cur_seq; prv_tgt <= cur_tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else             err_q <= err_nxt;
  end

  assign cf_error = err_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_q |=> err_q);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tr_valid |=> $stable(err_q));
  // R1
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tr_valid && !prv_vld && !err_q) |=> !err_q);
  // R5
  stack_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tr_valid |-> !(ras_push || ras_pop));
endmodule

// File: tb/tb_cfc_monitor.sv
`timescale 1ns/1ps
module tb_cfc_monitor;
  localparam logic [4:0] NOP = 5'h00, JMP = 5'h1A, JCC = 5'h1B,
                         CALL = 5'h18, CALLC = 5'h19, RET = 5'h15, RETC = 5'h14;
  localparam int VEC = 16;

  logic clk = 1'b0, rst_n = 1'b0, tr_valid = 1'b0, tr_trap = 1'b0;
  logic [9:0]  tr_pc = '0;
  logic [17:0] tr_insn = '0;
  logic cf_error;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfc_monitor dut (.clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_pc(tr_pc),
                   .tr_insn(tr_insn), .tr_trap(tr_trap), .cf_error(cf_error));

  function automatic logic [17:0] mk(input logic [4:0] op, input int off);
    return {op, 3'b000, 10'(off)};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tr_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic beat(input int pc, input logic [17:0] insn, input logic trap = 1'b0);
    tr_valid = 1'b1; tr_pc = 10'(pc); tr_insn = insn; tr_trap = trap;
    @(negedge clk);
    tr_valid = 1'b0; tr_pc = ~10'(pc); tr_insn = mk(RET, 0); tr_trap = 1'b1;
    @(negedge clk);
  endtask

  task automatic expect_err(input logic exp, input string req);
    checks++;
    if (cf_error !== exp) begin
      failures++;
      $display("FAIL %s cf_error=%0b expected=%0b", req, cf_error, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: held reset and first beat
    repeat (2) @(negedge clk);
    expect_err(1'b0, "R1 during reset");
    do_reset();
    expect_err(1'b0, "R1 after reset");
    beat(777, mk(NOP, 0));
    expect_err(1'b0, "R1 first beat unchecked");

    // R2: whole space sequential with wrap
    do_reset();
    for (int i = 0; i <= 1024; i++) beat(i % 1024, mk(NOP, 0));
    expect_err(1'b0, "R2 sequential sweep");
    beat(5, mk(NOP, 0));
    expect_err(1'b1, "R2 skipped address");
    // R9 sticky
    beat(6, mk(NOP, 0)); beat(7, mk(NOP, 0));
    expect_err(1'b1, "R9 sticky");
    do_reset();
    expect_err(1'b0, "R9 cleared by reset");

    // R3: jump offsets
    for (int off = 0; off < 1024; off += 37) begin
      do_reset();
      beat(100, mk(JMP, off));
      beat((100 + off) % 1024, mk(NOP, 0));
      beat((101 + off) % 1024, mk(NOP, 0));
      expect_err(1'b0, "R3 jump target");
      do_reset();
      beat(100, mk(JMP, off));
      beat(101, mk(NOP, 0));
      expect_err((off % 1024) == 1 ? 1'b0 : 1'b1, "R3 jump not taken");
    end

    // R4: conditional jump
    do_reset(); beat(200, mk(JCC, 50)); beat(201, mk(NOP, 0));
    expect_err(1'b0, "R4 fallthrough");
    do_reset(); beat(200, mk(JCC, 50)); beat(250, mk(NOP, 0));
    expect_err(1'b0, "R4 taken");
    do_reset(); beat(1000, mk(JCC, 100)); beat(76, mk(NOP, 0));
    expect_err(1'b0, "R4 taken wrap");
    do_reset(); beat(200, mk(JCC, 50)); beat(202, mk(NOP, 0));
    expect_err(1'b1, "R4 other address");

    // R5: nested calls
    do_reset();
    beat(10, mk(CALL, 90)); beat(100, mk(CALL, 100)); beat(200, mk(CALL, 100));
    beat(300, mk(RET, 0)); beat(201, mk(RET, 0)); beat(101, mk(RET, 0));
    beat(11, mk(NOP, 0));
    expect_err(1'b0, "R5 nested returns");
    beat(12, mk(RET, 0)); beat(700, mk(NOP, 0));
    expect_err(1'b0, "R7 return on empty");
    do_reset(); beat(10, mk(CALL, 90)); beat(100, mk(RET, 0)); beat(12, mk(NOP, 0));
    expect_err(1'b1, "R5 wrong return");
    do_reset(); beat(10, mk(CALL, 90)); beat(11, mk(NOP, 0));
    expect_err(1'b1, "R5 call not at target");

    // R7: overflow drops oldest
    do_reset();
    beat(10, mk(CALL, 90)); beat(100, mk(CALL, 100));
    beat(200, mk(CALL, 100)); beat(300, mk(CALL, 100));
    beat(400, mk(RET, 0)); beat(301, mk(RET, 0)); beat(201, mk(RET, 0));
    expect_err(1'b0, "R7 newest three kept");
    beat(101, mk(RET, 0)); beat(555, mk(NOP, 0));
    expect_err(1'b0, "R7 oldest dropped");

    // R6: conditional call and return
    do_reset();
    beat(10, mk(CALL, 90)); beat(100, mk(CALLC, 50)); beat(101, mk(RET, 0));
    beat(11, mk(NOP, 0));
    expect_err(1'b0, "R6 callc not taken no push");
    do_reset();
    beat(10, mk(CALL, 90)); beat(100, mk(CALLC, 50)); beat(150, mk(RET, 0));
    beat(101, mk(RET, 0)); beat(11, mk(NOP, 0));
    expect_err(1'b0, "R6 callc taken push");
    do_reset(); beat(100, mk(CALLC, 50)); beat(150, mk(RET, 0)); beat(11, mk(NOP, 0));
    expect_err(1'b1, "R6 callc return mismatch");
    do_reset();
    beat(10, mk(CALL, 90)); beat(100, mk(RETC, 0)); beat(101, mk(RET, 0));
    beat(11, mk(NOP, 0));
    expect_err(1'b0, "R6 retc not taken no pop");
    do_reset(); beat(10, mk(CALL, 90)); beat(100, mk(RETC, 0)); beat(11, mk(NOP, 0));
    expect_err(1'b0, "R6 retc taken");
    do_reset(); beat(10, mk(CALL, 90)); beat(100, mk(RETC, 0)); beat(55, mk(NOP, 0));
    expect_err(1'b1, "R6 retc other address");

    // R8: trap
    do_reset();
    beat(300, mk(NOP, 0), 1'b1); beat(VEC, mk(RET, 0)); beat(301, mk(NOP, 0));
    expect_err(1'b0, "R8 vector and return");
    do_reset(); beat(300, mk(JMP, 5), 1'b1); beat(VEC, mk(NOP, 0));
    expect_err(1'b0, "R8 trap overrides jump");
    do_reset(); beat(300, mk(NOP, 0), 1'b1); beat(301, mk(NOP, 0));
    expect_err(1'b1, "R8 missed vector");

    // R10: idle cycles with garbage
    do_reset();
    beat(5, mk(NOP, 0));
    for (int k = 0; k < 6; k++) begin
      tr_pc = 10'(k * 97); tr_insn = mk(JMP, k); tr_trap = k[0];
      @(negedge clk);
    end
    beat(6, mk(NOP, 0));
    expect_err(1'b0, "R10 idle ignored");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule